// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps transitions on an external event line. The line is first resynchronised to the functional clock. Its transitions are then qualified against a programmable polarity. On each qualifying transition the current value of a free-running counter is copied into a capture register. The counter is kept outside the block and arrives on an input port. Settings come from three fields of the timer's shared control word: the polarity code, a pairing mode flag and the pin direction flag. Both capture registers are exposed for read.

With pairing off, every qualifying transition overwrites the first register. With pairing on, two successive transitions fill the first register and then the second, after which the sequence starts over. Each latch also produces a one-cycle event pulse for the status logic downstream. Disabling capture, or leaving pairing mode, returns the sequence to the first register.

Top module: `tmr_capture_unit`

## Requirements
- R1: After a synchronous reset, both capture registers read zero and the event pulse is low.
- R2: The event line passes through two flip-flops before edge detection. A change driven before rising clock edge k is latched at edge k+2, using the counter value present at edge k+2.
- R3: Polarity code 01 (control bits 9:8) captures only low-to-high transitions.
- R4: Polarity code 10 captures only high-to-low transitions.
- R5: Polarity code 11 captures both transitions.
- R6: Polarity code 00 disables capture: both registers hold and no pulse is produced.
- R7: With control bit 14 clear (pin used as an output), no capture takes place. With it set, the pin acts as the capture input.
- R8: With control bit 13 clear, every qualifying transition loads the first register, and the second register holds.
- R9: With control bit 13 set, one qualifying transition loads the first register and the next one loads the second register, alternating from then on.
- R10: The event pulse is high for exactly the cycle in which a register has just been loaded, one pulse per capture.
- R11: While capture is disabled (R6, R7), or while bit 13 is clear, the pairing sequence is held at the first register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Shared timer control word. Bits 9:8 are the polarity, bit 13 the pairing mode, bit 14 the pin direction |
| count_in | input | 32 | Free-running counter value |
| evt_in | input | 1 | Asynchronous external event line |
| cap1_q | output | 32 | First capture register |
| cap2_q | output | 32 | Second capture register |
| cap_pulse | output | 1 | One-cycle capture event toward the status logic |

## Verification
A qualifying transition can reach the detector in the same cycle that the control word changes the pairing mode or disables capture. When that happens, latching and rearming of the sequencer meet at one clock edge. The random phase changes the control word on many cycles while the event line is toggling, so such coincidences occur often. A cycle-accurate bench model derived from R2 and R8 to R11 then decides which register must have been loaded, if any, and where the sequence must stand afterwards.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    EDG_OFF  = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge
  import tcap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  edge_sel_e sel,
  input  logic      enable,
  output logic      hit
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    hit = 1'b0;
    if (enable) begin
      unique case (sel)
        EDG_RISE: hit = rise;
        EDG_FALL: hit = fall;
        EDG_ANY:  hit = rise | fall;
        default:  hit = 1'b0;
      endcase
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (sel == EDG_OFF) |-> !hit); // R6
  AST_RISE_ONLY_RISE: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == EDG_RISE) |-> (lvl && !prev_q)); // R3
  AST_FALL_ONLY_FALL: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == EDG_FALL) |-> (!lvl && prev_q)); // R4
endmodule

// File: rtl/tcap_latch.sv
module tcap_latch #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             armed,
  input  logic             pair_mode,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap1_q,
  output logic [CNT_W-1:0] cap2_q,
  output logic             pulse_q
);
  logic slot_q;
  logic to_second;

  assign to_second = pair_mode & slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap1_q  <= '0;
      cap2_q  <= '0;
      pulse_q <= 1'b0;
      slot_q  <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (hit) begin
        if (to_second) cap2_q <= count;
        else           cap1_q <= count;
      end
      if (!armed || !pair_mode) slot_q <= 1'b0;
      else if (hit)             slot_q <= ~slot_q;
    end
  end

  AST_HOLD_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(cap1_q) && $stable(cap2_q))); // R6
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    hit |=> pulse_q); // R10
  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !pulse_q); // R10
  AST_SINGLE_KEEPS2: assert property (@(posedge clk) disable iff (rst)
    !pair_mode |=> $stable(cap2_q)); // R8
  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    (!armed || !pair_mode) |=> !slot_q); // R11
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcap_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int CTRL_W   = 32,
  parameter int SYNC_N   = 2,
  parameter int EDGE_LSB = 8,
  parameter int MODE_BIT = 13,
  parameter int PIN_BIT  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              evt_in,
  output logic [CNT_W-1:0]  cap1_q,
  output logic [CNT_W-1:0]  cap2_q,
  output logic              cap_pulse
);
  localparam int EDGE_MSB = EDGE_LSB + 1;

  edge_sel_e sel;
  logic      pin_is_input, pair_mode, armed;
  logic      evt_sync, hit;

  assign sel          = edge_sel_e'(ctrl_word[EDGE_MSB:EDGE_LSB]);
  assign pin_is_input = ctrl_word[PIN_BIT];
  assign pair_mode    = ctrl_word[MODE_BIT];
  assign armed        = pin_is_input && (sel != EDG_OFF);

  tcap_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(evt_in), .q(evt_sync)
  );

  tcap_edge u_edge (
    .clk(clk), .rst(rst), .lvl(evt_sync), .sel(sel),
    .enable(armed), .hit(hit)
  );

  tcap_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst(rst), .hit(hit), .armed(armed),
    .pair_mode(pair_mode), .count(count_in),
    .cap1_q(cap1_q), .cap2_q(cap2_q), .pulse_q(cap_pulse)
  );

  AST_OUTPUT_PIN_SILENT: assert property (@(posedge clk) disable iff (rst)
    !pin_is_input |=> !cap_pulse); // R7
endmodule

// File: tb/tb_tmr_capture_unit.sv
module tb_tmr_capture_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrl_word = '0;
  logic [31:0] count_in = '0;
  logic        evt_in = 1'b0;
  logic [31:0] cap1_q, cap2_q;
  logic        cap_pulse;

  tmr_capture_unit dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .count_in(count_in),
    .evt_in(evt_in), .cap1_q(cap1_q), .cap2_q(cap2_q), .cap_pulse(cap_pulse)
  );

  always #4 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] cnt = 32'h100;

  // bench model state
  logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_slot = 0, m_pulse = 0;
  logic [31:0] m_c1 = 0, m_c2 = 0;

  function automatic logic qualifies(logic [31:0] c, logic s2, logic pv);
    logic [1:0] e;
    e = c[9:8];
    if (!c[14] || e == 2'b00) return 1'b0;           // R6 R7
    if (e == 2'b01) return s2 & ~pv;                 // R3
    if (e == 2'b10) return ~s2 & pv;                 // R4
    return s2 ^ pv;                                  // R5
  endfunction

  function automatic logic [31:0] mk(bit pin, bit pair, logic [1:0] e);
    logic [31:0] c;
    c = $urandom() & ~32'h0000_6300;
    c[14] = pin; c[13] = pair; c[9:8] = e;
    return c;
  endfunction

  task automatic model_edge();
    logic h;
    h = qualifies(ctrl_word, m_s2, m_prev);
    m_pulse = h;                                     // R10
    if (h) begin
      if (ctrl_word[13] && m_slot) m_c2 = count_in;  // R9
      else                         m_c1 = count_in;  // R8
    end
    if (!ctrl_word[14] || ctrl_word[9:8] == 2'b00 || !ctrl_word[13]) m_slot = 0; // R11
    else if (h) m_slot = ~m_slot;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = evt_in;       // R2
  endtask

  task automatic compare(string tag);
    n_vec++;
    if (cap1_q !== m_c1 || cap2_q !== m_c2 || cap_pulse !== m_pulse) begin
      n_bad++;
      $display("FAIL %s: cap1=%h cap2=%h pulse=%b, expected cap1=%h cap2=%h pulse=%b",
               tag, cap1_q, cap2_q, cap_pulse, m_c1, m_c2, m_pulse);
    end
  endtask

  task automatic step(logic e, logic [31:0] c, string tag);
    @(negedge clk);
    evt_in = e; ctrl_word = c; count_in = cnt; cnt = cnt + 32'd3;
    @(posedge clk);
    model_edge();
    #2 compare(tag);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
  end

  initial begin
    logic [31:0] c;
    logic e;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 compare("R1 reset");
    // R3 rising, single mode: rise captured, fall ignored; latency R2
    c = mk(1, 0, 2'b01);
    step(0, c, "R3"); step(1, c, "R2 R3"); step(1, c, "R2"); step(1, c, "R2 R10");
    step(0, c, "R3"); step(0, c, "R3"); step(0, c, "R3");
    // R4 falling
    c = mk(1, 0, 2'b10);
    step(1, c, "R4"); step(1, c, "R4"); step(1, c, "R4");
    step(0, c, "R4"); step(0, c, "R4"); step(0, c, "R4");
    // R5 both edges, fast toggling gives back-to-back pulses
    c = mk(1, 0, 2'b11);
    for (int i = 0; i < 8; i++) step(i[0], c, "R5 R10");
    // R6 code 00 ignored
    c = mk(1, 1, 2'b00);
    for (int i = 0; i < 6; i++) step(i[1], c, "R6");
    // R7 pin as output ignored
    c = mk(0, 1, 2'b11);
    for (int i = 0; i < 6; i++) step(i[1], c, "R7");
    // R9 pairing: alternate registers
    c = mk(1, 1, 2'b01);
    for (int i = 0; i < 16; i++) step(i[1], c, "R9");
    // R11 rearm: one capture, then leave pairing, then return
    step(1, c, "R11"); step(1, c, "R11"); step(1, c, "R11");
    c = mk(1, 0, 2'b01); step(0, c, "R11"); step(0, c, "R11");
    c = mk(1, 1, 2'b01);
    for (int i = 0; i < 8; i++) step(i[1], c, "R11 R9");
    // R8 single mode: second register holds
    c = mk(1, 0, 2'b11);
    for (int i = 0; i < 8; i++) step(i[0], c, "R8");
    // random phase
    e = 0;
    c = mk(1, 1, 2'b11);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) e = ~e;
      if ($urandom_range(7) == 0)
        c = mk($urandom_range(5) != 0, $urandom_range(1), 2'($urandom_range(3)));
      step(e, c, "R3/R4/R5/R6/R7/R8/R9/R11 random");
    end
    report();
  end
endmodule